// File: doc/BRIEF.md
# Trace Stimulus Write Decoder

This block sits behind a large memory-mapped window that software writes trace data into. The window is cut into per-channel slots, and each slot is cut into two halves. Every accepted write becomes one trace element record. The record holds the channel taken from the upper address bits, the element size taken from the access size, the payload zero-extended to 32 bits, and a flag that is set when the write landed in the upper half of the slot. Software writes a one- or two-word header and the body of a message to the lower half, and writes only the last element of the message to the upper half. The set flag therefore marks the element that closes the message and carries a timestamp downstream.

Records pass through a small FIFO and leave on a valid/ready stream that feeds the trace serialiser. When the FIFO is full, the write port is held off with a wait signal, so no element is lost. While the module enable input is low, writes complete at once and leave nothing behind.

Top module: `trace_stim_decoder`

## Requirements
- R1: The channel field equals write address bits [19:12]. Address bits [10:0] have no effect on any field of the record.
- R2: The stamp flag equals write address bit 11. An offset of 2048 or more within a channel slot gives a set flag, and a lower offset gives a clear flag.
- R3: Size code 0 records a byte, size code 1 a halfword and size code 2 a word, and the code is copied into the size field. Data bits above the element width read as zero in the record.
- R4: A write with size code 3 produces no element.
- R5: While modEn is low, a write is never held off (wrWait stays low) and produces no element.
- R6: outRec is laid out as channel in bits [42:35], size in [34:33], stamp flag in [32] and data in [31:0].
- R7: Elements leave in the order their writes were accepted. An element is offered on outValid in the cycle after the clock edge that accepted its write.
- R8: With modEn high, wrWait is high exactly when the FIFO holds 4 elements. A write held by wrWait is accepted intact once space frees.
- R9: While outValid is high and outReady is low, outValid stays high and outRec does not change.
- R10: After reset, outValid and wrWait are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modEn | input | 1 | Module enable; writes are discarded while low |
| wrValid | input | 1 | A write is presented |
| wrAddr | input | 20 | Byte offset of the write into the channel window |
| wrSize | input | 2 | Access size code: 0 byte, 1 halfword, 2 word, 3 invalid |
| wrData | input | 32 | Write data, right-aligned |
| wrWait | output | 1 | Holds the presented write off while the FIFO is full |
| outValid | output | 1 | A decoded element is offered |
| outReady | input | 1 | Downstream takes the offered element |
| outRec | output | 43 | Decoded element record |

## Verification
The embedded properties check on every cycle that occupancy never passes the FIFO depth, that a held write is backed by a non-empty FIFO, that a stalled record stays frozen, that byte records carry zero upper data, and that disabled or invalid-size writes leave an empty stream empty. The decode itself can only be shown by the bench's scenarios. That includes channel and half selection from arbitrary low address bits, halfword masking, exact element ordering under random back-pressure, and the release of a held write with its data intact. In these scenarios a queue-based model is compared against the ports on every clock.

// File: rtl/trace_stim_pkg.sv
package trace_stim_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } elemSize_e;

  typedef struct packed {
    logic push;
    logic pop;
  } fifoStrobe_t;

endpackage

// File: rtl/trace_stim_ctrl.sv
module trace_stim_ctrl
  import trace_stim_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        modEn,
  input  logic        wrValid,
  input  logic [1:0]  wrSize,
  input  logic        outReady,
  output logic        wrWait,
  output logic        outValid,
  output fifoStrobe_t strb
);

  logic [CNT_W-1:0] fillCount;
  logic             isFull;

  assign isFull   = (fillCount == CNT_W'(DEPTH));
  assign outValid = (fillCount != '0);
  assign wrWait   = modEn && isFull;

  always_comb begin
    strb.push = wrValid && modEn && !isFull && (wrSize != SZ_BAD);
    strb.pop  = outValid && outReady;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillCount <= '0;
    end else begin
      case ({strb.push, strb.pop})
        2'b10:   fillCount <= fillCount + 1'b1;
        2'b01:   fillCount <= fillCount - 1'b1;
        default: fillCount <= fillCount;
      endcase
    end
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= CNT_W'(DEPTH));

  // R8
  held_nonempty_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && wrWait |=> outValid);

endmodule

// File: rtl/trace_stim_dpath.sv
module trace_stim_dpath
  import trace_stim_pkg::*;
#(
  parameter int CHAN_W = 8,
  parameter int WIN_W  = 12,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int ADDR_W = CHAN_W + WIN_W,
  localparam int REC_W  = CHAN_W + 2 + 1 + DATA_W,
  localparam int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobe_t       strb,
  input  logic              outValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [1:0]        wrSize,
  input  logic [DATA_W-1:0] wrData,
  output logic [REC_W-1:0]  outRec
);

  logic [DATA_W-1:0] maskedData;
  logic [REC_W-1:0]  newRec;
  logic [REC_W-1:0]  slots [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;

  always_comb begin
    maskedData = '0;
    case (wrSize)
      SZ_BYTE: maskedData[7:0]  = wrData[7:0];
      SZ_HALF: maskedData[15:0] = wrData[15:0];
      default: maskedData       = wrData;
    endcase
    newRec = {wrAddr[ADDR_W-1:WIN_W], wrSize, wrAddr[WIN_W-1], maskedData};
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strb.push && (wrPtr == PTR_W'(i))) slots[i] <= newRec;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.push) wrPtr <= wrPtr + 1'b1;
      if (strb.pop)  rdPtr <= rdPtr + 1'b1;
    end
  end

  assign outRec = slots[rdPtr];

  // R3
  zero_ext_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && (outRec[DATA_W+2:DATA_W+1] == SZ_BYTE) |-> (outRec[DATA_W-1:8] == '0));

endmodule

// File: rtl/trace_stim_decoder.sv
module trace_stim_decoder
  import trace_stim_pkg::*;
#(
  parameter int CHAN_W = 8,
  parameter int WIN_W  = 12,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int ADDR_W = CHAN_W + WIN_W,
  localparam int REC_W  = CHAN_W + 2 + 1 + DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modEn,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [1:0]        wrSize,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrWait,
  output logic              outValid,
  input  logic              outReady,
  output logic [REC_W-1:0]  outRec
);

  fifoStrobe_t strb;

  trace_stim_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .modEn(modEn), .wrValid(wrValid),
    .wrSize(wrSize), .outReady(outReady), .wrWait(wrWait),
    .outValid(outValid), .strb(strb)
  );

  trace_stim_dpath #(.CHAN_W(CHAN_W), .WIN_W(WIN_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .outValid(outValid),
    .wrAddr(wrAddr), .wrSize(wrSize), .wrData(wrData), .outRec(outRec)
  );

  // R9
  rec_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outRec));

  // R5
  disabled_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !modEn && !outValid |=> !outValid);

  // R4
  bad_size_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && (wrSize == SZ_BAD) && !outValid |=> !outValid);

endmodule

// File: tb/trace_stim_decoder_test.sv
`timescale 1ns/1ps
module trace_stim_decoder_test;

  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modEn = 1'b0;
  logic        wrValid = 1'b0;
  logic [19:0] wrAddr = '0;
  logic [1:0]  wrSize = '0;
  logic [31:0] wrData = '0;
  logic        outReady = 1'b0;
  logic        wrWait;
  logic        outValid;
  logic [42:0] outRec;

  int checks = 0;
  int errors = 0;
  string phase = "R10";
  int readyMode = 0;   // 0 always ready, 1 stalled, 2 random
  bit heldFlag = 0;
  logic [42:0] refQ[$];

  always #2 clk = ~clk;

  trace_stim_decoder uut (
    .clk(clk), .rstN(rstN), .modEn(modEn), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrSize(wrSize), .wrData(wrData), .wrWait(wrWait), .outValid(outValid),
    .outReady(outReady), .outRec(outRec)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [42:0] expRec(logic [19:0] a, logic [1:0] s, logic [31:0] d);
    logic [31:0] m;
    if (s == 2'd0) m = d & 32'hFF;
    else if (s == 2'd1) m = d & 32'hFFFF;
    else m = d;
    return {a[19:12], s, a[11], m};
  endfunction

  // behavioural reference, updated on every clock
  always @(posedge clk) begin
    if (!rstN) begin
      refQ.delete();
      heldFlag = 0;
    end else begin
      bit doPop, doPush;
      doPop  = (refQ.size() > 0) && outReady;
      heldFlag = wrValid && modEn && (refQ.size() == DEPTH);
      doPush = wrValid && modEn && (refQ.size() < DEPTH) && (wrSize != 2'd3);
      if (doPop) void'(refQ.pop_front());
      if (doPush) refQ.push_back(expRec(wrAddr, wrSize, wrData));
    end
  end

  // compare after outputs settle, before inputs move
  always @(posedge clk) begin
    #1;
    if (rstN) begin
      check({phase, " wait"}, 64'(wrWait), 64'(modEn && (refQ.size() == DEPTH)));
      check({phase, " valid"}, 64'(outValid), 64'(refQ.size() > 0));
      if (refQ.size() > 0) check({phase, " record"}, 64'(outRec), 64'(refQ[0]));
    end
  end

  always @(negedge clk) begin
    case (readyMode)
      0: outReady <= 1'b1;
      1: outReady <= 1'b0;
      default: outReady <= 1'($urandom_range(0, 1));
    endcase
  end

  // call at a negedge; returns at the negedge after acceptance
  task automatic doWrite(logic [19:0] a, logic [1:0] s, logic [31:0] d);
    wrValid = 1'b1; wrAddr = a; wrSize = s; wrData = d;
    do @(negedge clk); while (heldFlag);
    wrValid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    readyMode = 1;
    idle(3);
    rstN = 1'b1;
    @(posedge clk); #1;
    // R10 reset state
    check("R10 outValid", 64'(outValid), 64'd0);
    check("R10 wrWait", 64'(wrWait), 64'd0);
    @(negedge clk);
    modEn = 1'b1;
    readyMode = 0;

    phase = "R1";
    for (int i = 0; i < 8; i++)
      doWrite({8'(i * 37 + 5), 1'b0, 11'($urandom)}, 2'd2, $urandom);
    idle(3);

    phase = "R2";
    doWrite(20'h0_37FF, 2'd2, 32'h1111_2222);
    doWrite(20'h0_3800, 2'd2, 32'h3333_4444);
    doWrite(20'hF_FFFF, 2'd0, 32'h55);
    idle(3);

    phase = "R3";
    doWrite(20'h4_0010, 2'd0, 32'hDEAD_BEEF);
    doWrite(20'h4_0020, 2'd1, 32'hDEAD_BEEF);
    doWrite(20'h4_0830, 2'd2, 32'hDEAD_BEEF);
    idle(3);

    phase = "R4";
    doWrite(20'h5_0000, 2'd3, 32'h1234_5678);
    idle(2);
    check("R4 no element", 64'(outValid), 64'd0);

    phase = "R5";
    modEn = 1'b0;
    readyMode = 1;
    for (int i = 0; i < 6; i++) doWrite(20'h6_0000 + 20'(i), 2'd2, 32'(i));
    idle(2);
    check("R5 no element", 64'(outValid), 64'd0);
    check("R5 no wait", 64'(wrWait), 64'd0);
    modEn = 1'b1;

    phase = "R6";
    doWrite(20'hA_5812, 2'd1, 32'hFFFF_1234);
    idle(1);
    check("R6 layout", 64'(outRec), 64'({8'hA5, 2'd1, 1'b1, 32'h0000_1234}));
    readyMode = 0;
    idle(3);

    phase = "R8 R9";
    readyMode = 1;
    fork
      begin idle(12); readyMode = 0; end
    join_none
    for (int i = 0; i < 7; i++) doWrite({8'(i + 16), 12'h804}, 2'd2, 32'hC0DE_0000 + 32'(i));
    idle(6);

    phase = "R7";
    readyMode = 2;
    for (int i = 0; i < 60; i++)
      doWrite(20'($urandom), 2'($urandom_range(0, 2)), $urandom);
    readyMode = 0;
    idle(8);
    check("R7 drained", 64'(outValid), 64'd0);

    finishRun();
  end

endmodule